// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair with Acknowledge Vectoring

This block combines two eight-line interrupt resolvers into one system with fifteen usable request lines. The slave resolver takes lines 8 to 15. Its "has a deliverable request" condition is forwarded as a one-shot request onto line 2 of the master resolver. The master takes lines 0, 1 and 3 to 7 directly. The master's deliverable condition drives the CPU interrupt line. Each resolver keeps a request register, a mask register, an in-service register, a trigger-select register and a programmed vector base. Line 0 has the highest priority within a resolver.

When the CPU pulses the acknowledge input, the block returns an 8-bit vector one cycle later. The vector is built from the base of whichever resolver supplied the interrupt, plus the line index. If nothing is actually deliverable, the block returns a spurious vector (base + 7) instead. Software programs and inspects both resolvers through a small byte-wide port bus. That bus decodes two address pairs for the resolvers and two single addresses for the trigger-select registers. Each trigger-select register is filtered through a fixed writable-bit mask.

Top module: `pic_cascade`

## Requirements
- R1: After reset, `cpu_int` and `vec_valid` are low, `vec_out` is 0x00, and the mask, trigger-select and in-service registers of both resolvers read back as 0x00.
- R2: When a line's trigger-select bit is 0, a rising edge latches a request, and acknowledging it clears the request. A line held high after its acknowledge and EOI raises no new interrupt.
- R3: When a line's trigger-select bit is 1, its request follows the line level and survives acknowledge. After EOI, a line still held high interrupts again.
- R4: A line whose mask bit is 1 never raises `cpu_int`, but its request is still visible in the request-register read. Clearing the mask bit raises `cpu_int` by the next sample.
- R5: The lowest-numbered unmasked request wins, and only if it has higher priority than every in-service line. Command byte 0x20 clears the highest-priority in-service bit, and 0x60|n clears bit n. A follow-on request is presented on the cycle after the acknowledge or EOI, with no further software action.
- R6: An acknowledge pulse on `inta` produces `vec_valid` high for exactly the following cycle. When the master winner is not line 2, `vec_out` = master base (bits 7:3) + winner index.
- R7: A slave deliverable request sets master request bit 2 one cycle later. An acknowledge that then selects master line 2 sets in-service bit 2 in the master and the winner's bit in the slave, and returns slave base + slave winner index.
- R8: Acknowledge with no deliverable master request returns master base + 7 and changes no in-service bit.
- R9: Acknowledge that selects master line 2 while the slave has nothing deliverable returns slave base + 7.
- R10: The port map is as follows. 0x20 is the master command / request-or-in-service read, and 0x21 the master data / mask. 0xA0 and 0xA1 are the same pair for the slave. 0x4D0 is the master trigger-select and 0x4D1 the slave trigger-select. Trigger-select writes are ANDed with 0xF8 (master) and 0xDE (slave). Read data appears on `bus_rdata` the cycle after `bus_rd`.
- R11: A write or read whose `bus_len` is not 1 changes no register. A read of that kind returns 0x00.
- R12: A command byte with bit 4 set clears the mask, keeps only level-mode requests, and makes the next data write load the vector base from bits 7:3. A command byte with bit 3 set and bit 1 set selects, through bit 0, whether offset 0 reads the in-service register (1) or the request register (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Request lines; bits 7:0 master (bit 2 unused), bits 15:8 slave |
| inta | input | 1 | One-cycle interrupt acknowledge strobe |
| bus_addr | input | 16 | Port address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_len | input | 3 | Access width in bytes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cpu_int | output | 1 | Interrupt request to the CPU |
| vec_out | output | 8 | Acknowledge vector |
| vec_valid | output | 1 | Vector valid, one cycle after `inta` |

## Verification
The bench builds the block with its default parameters: the standard port addresses, cascade on master line 2, and the 0xF8 and 0xDE trigger masks. These defaults make the masked trigger-select read-back reachable. They also let a level-mode slave line (slave line 1) create a latched master cascade request whose source vanishes before the acknowledge, which exercises the slave-spurious path. With the eight-line width, every priority, in-service-blocking and specific-EOI case is reachable in a few hundred cycles.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NLINE  = 8;
    localparam int IDX_W  = $clog2(NLINE);
    localparam int DATA_W = 8;
    localparam int BASE_W = DATA_W - IDX_W;
    localparam int LEN_W  = 3;

    typedef struct packed {
        logic m_cmd;
        logic m_data;
        logic s_cmd;
        logic s_data;
        logic m_trig;
        logic s_trig;
    } port_sel_t;

    // Index of the lowest set bit, or NLINE when the vector is empty.
    function automatic logic [IDX_W:0] lowest_set(input logic [NLINE-1:0] v);
        logic [IDX_W:0] r;
        r = (IDX_W+1)'(NLINE);
        for (int i = NLINE - 1; i >= 0; i--) begin
            if (v[i]) r = (IDX_W+1)'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_resolver.sv
module irq_resolver
    import pic_pkg::*;
#(
    parameter logic [NLINE-1:0] TRIG_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NLINE-1:0]   lines,
    input  logic [NLINE-1:0]   set_pulse,
    input  logic               cmd_wr,
    input  logic               data_wr,
    input  logic               trig_wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               ack,
    output logic               deliv,
    output logic [IDX_W-1:0]   win,
    output logic [BASE_W-1:0]  base,
    output logic [NLINE-1:0]   irr,
    output logic [NLINE-1:0]   isr,
    output logic [NLINE-1:0]   imr,
    output logic [NLINE-1:0]   trig,
    output logic               read_isr
);
    typedef struct packed {
        logic [NLINE-1:0]  irr;
        logic [NLINE-1:0]  isr;
        logic [NLINE-1:0]  imr;
        logic [NLINE-1:0]  trig;
        logic [NLINE-1:0]  last;
        logic [BASE_W-1:0] base;
        logic              init_wait;
        logic              read_isr;
    } res_state_t;

    res_state_t st_q, st_d;
    logic [IDX_W:0] req_pri, isr_pri;

    always_comb begin
        req_pri = lowest_set(st_q.irr & ~st_q.imr);
        isr_pri = lowest_set(st_q.isr);
        deliv   = (req_pri != (IDX_W+1)'(NLINE)) && (req_pri < isr_pri);
        win     = req_pri[IDX_W-1:0];
    end

    always_comb begin
        st_d      = st_q;
        st_d.last = lines;
        // edge-mode bits latch rising edges, level-mode bits follow the line
        st_d.irr  = ((st_q.irr | (lines & ~st_q.last)) & ~st_q.trig)
                  | (lines & st_q.trig) | set_pulse;

        if (cmd_wr) begin
            if (wdata[4]) begin
                st_d.irr       = st_d.irr & st_q.trig;
                st_d.imr       = '0;
                st_d.last      = '0;
                st_d.init_wait = 1'b1;
                st_d.read_isr  = 1'b0;
            end else if (wdata[3]) begin
                if (wdata[1]) st_d.read_isr = wdata[0];
            end else begin
                case (wdata[7:5])
                    3'b001: begin
                        if (isr_pri != (IDX_W+1)'(NLINE))
                            st_d.isr[isr_pri[IDX_W-1:0]] = 1'b0;
                    end
                    3'b011: st_d.isr[wdata[IDX_W-1:0]] = 1'b0;
                    default: ;
                endcase
            end
        end

        if (data_wr) begin
            if (st_q.init_wait) begin
                st_d.base      = wdata[DATA_W-1:IDX_W];
                st_d.init_wait = 1'b0;
            end else begin
                st_d.imr = wdata;
            end
        end

        if (trig_wr) st_d.trig = wdata & TRIG_MASK;

        // acknowledge is applied last so its clear wins over same-cycle sets
        if (ack && deliv) begin
            st_d.isr[win] = 1'b1;
            if (!st_q.trig[win]) st_d.irr[win] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base     = st_q.base;
    assign irr      = st_q.irr;
    assign isr      = st_q.isr;
    assign imr      = st_q.imr;
    assign trig     = st_q.trig;
    assign read_isr = st_q.read_isr;
endmodule

// File: rtl/port_decode.sv
module port_decode
    import pic_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] MASTER_ADDR = 16'h0020,
    parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 16'h00A0,
    parameter logic [ADDR_W-1:0] TRIG_ADDR   = 16'h04D0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [LEN_W-1:0]  len,
    output port_sel_t         wr_sel,
    output port_sel_t         rd_sel
);
    port_sel_t hit;
    logic      byte_ok;

    always_comb begin
        byte_ok    = (len == LEN_W'(1));
        hit.m_cmd  = (addr[ADDR_W-1:1] == MASTER_ADDR[ADDR_W-1:1]) && !addr[0];
        hit.m_data = (addr[ADDR_W-1:1] == MASTER_ADDR[ADDR_W-1:1]) &&  addr[0];
        hit.s_cmd  = (addr[ADDR_W-1:1] == SLAVE_ADDR[ADDR_W-1:1])  && !addr[0];
        hit.s_data = (addr[ADDR_W-1:1] == SLAVE_ADDR[ADDR_W-1:1])  &&  addr[0];
        hit.m_trig = (addr[ADDR_W-1:1] == TRIG_ADDR[ADDR_W-1:1])   && !addr[0];
        hit.s_trig = (addr[ADDR_W-1:1] == TRIG_ADDR[ADDR_W-1:1])   &&  addr[0];
        wr_sel     = (wr && byte_ok) ? hit : '0;
        rd_sel     = (rd && byte_ok) ? hit : '0;
    end
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
    import pic_pkg::*;
#(
    parameter int                ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] MASTER_ADDR  = 16'h0020,
    parameter logic [ADDR_W-1:0] SLAVE_ADDR   = 16'h00A0,
    parameter logic [ADDR_W-1:0] TRIG_ADDR    = 16'h04D0,
    parameter logic [7:0]        M_TRIG_MASK  = 8'hF8,
    parameter logic [7:0]        S_TRIG_MASK  = 8'hDE,
    parameter int                CASCADE_LINE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       irq_lines,
    input  logic              inta,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_len,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              cpu_int,
    output logic [7:0]        vec_out,
    output logic              vec_valid
);
    localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(NLINE - 1);
    localparam logic [NLINE-1:0] CASC_BIT = NLINE'(1) << CASCADE_LINE;

    typedef struct packed {
        logic [DATA_W-1:0] vec;
        logic              vec_valid;
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t top_q, top_d;
    port_sel_t  wr_sel, rd_sel;

    logic             m_deliv, s_deliv, m_rdsel, s_rdsel, s_ack;
    logic [IDX_W-1:0] m_win, s_win;
    logic [BASE_W-1:0] m_base, s_base;
    logic [NLINE-1:0] m_irr, m_isr, m_imr, m_trig;
    logic [NLINE-1:0] s_irr, s_isr, s_imr, s_trig;
    logic [NLINE-1:0] m_lines, m_pulse;

    port_decode #(
        .ADDR_W(ADDR_W), .MASTER_ADDR(MASTER_ADDR),
        .SLAVE_ADDR(SLAVE_ADDR), .TRIG_ADDR(TRIG_ADDR)
    ) u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .len(bus_len),
        .wr_sel(wr_sel), .rd_sel(rd_sel)
    );

    always_comb begin
        m_lines = irq_lines[NLINE-1:0] & ~CASC_BIT;
        m_pulse = s_deliv ? CASC_BIT : '0;
        s_ack   = inta && m_deliv && (m_win == IDX_W'(CASCADE_LINE));
    end

    irq_resolver #(.TRIG_MASK(M_TRIG_MASK)) u_master (
        .clk(clk), .rst_n(rst_n), .lines(m_lines), .set_pulse(m_pulse),
        .cmd_wr(wr_sel.m_cmd), .data_wr(wr_sel.m_data), .trig_wr(wr_sel.m_trig),
        .wdata(bus_wdata), .ack(inta),
        .deliv(m_deliv), .win(m_win), .base(m_base),
        .irr(m_irr), .isr(m_isr), .imr(m_imr), .trig(m_trig), .read_isr(m_rdsel)
    );

    irq_resolver #(.TRIG_MASK(S_TRIG_MASK)) u_slave (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines[2*NLINE-1:NLINE]), .set_pulse('0),
        .cmd_wr(wr_sel.s_cmd), .data_wr(wr_sel.s_data), .trig_wr(wr_sel.s_trig),
        .wdata(bus_wdata), .ack(s_ack),
        .deliv(s_deliv), .win(s_win), .base(s_base),
        .irr(s_irr), .isr(s_isr), .imr(s_imr), .trig(s_trig), .read_isr(s_rdsel)
    );

    always_comb begin
        top_d           = top_q;
        top_d.vec_valid = inta;
        if (inta) begin
            if (!m_deliv)
                top_d.vec = {m_base, SPUR_IDX};
            else if (m_win == IDX_W'(CASCADE_LINE))
                top_d.vec = s_deliv ? {s_base, s_win} : {s_base, SPUR_IDX};
            else
                top_d.vec = {m_base, m_win};
        end

        if (rd_sel.m_cmd)       top_d.rdata = m_rdsel ? m_isr : m_irr;
        else if (rd_sel.m_data) top_d.rdata = m_imr;
        else if (rd_sel.s_cmd)  top_d.rdata = s_rdsel ? s_isr : s_irr;
        else if (rd_sel.s_data) top_d.rdata = s_imr;
        else if (rd_sel.m_trig) top_d.rdata = m_trig;
        else if (rd_sel.s_trig) top_d.rdata = s_trig;
        else                    top_d.rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign bus_rdata = top_q.rdata;
    assign vec_out   = top_q.vec;
    assign vec_valid = top_q.vec_valid;
    assign cpu_int   = m_deliv;
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk #(
    parameter logic [15:0] TRIG_ADDR   = 16'h04D0,
    parameter logic [7:0]  M_TRIG_MASK = 8'hF8,
    parameter logic [7:0]  S_TRIG_MASK = 8'hDE
) (
    input logic        clk,
    input logic        rst_n,
    input logic        inta,
    input logic        bus_wr,
    input logic [15:0] bus_addr,
    input logic [2:0]  bus_len,
    input logic [7:0]  bus_wdata,
    input logic        cpu_int,
    input logic        vec_valid,
    input logic [7:0]  vec_out,
    input logic        s_deliv,
    input logic [4:0]  m_base,
    input logic [7:0]  m_irr,
    input logic [7:0]  m_imr,
    input logic [7:0]  s_imr,
    input logic [7:0]  m_trig,
    input logic [7:0]  s_trig
);
    a_r6_valid_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(inta));

    a_r8_master_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !cpu_int) |=> (vec_out == {$past(m_base), 3'd7}));

    a_r7_cascade_sets_line2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_deliv && !inta && !bus_wr) |=> m_irr[2]);

    a_r10_master_trig_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_len == 3'd1 && bus_addr == TRIG_ADDR)
        |=> (m_trig == ($past(bus_wdata) & M_TRIG_MASK)));

    a_r10_slave_trig_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_len == 3'd1 && bus_addr == (TRIG_ADDR | 16'h0001))
        |=> (s_trig == ($past(bus_wdata) & S_TRIG_MASK)));

    a_r11_wide_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_len != 3'd1)
        |=> ($stable(m_imr) && $stable(s_imr) && $stable(m_trig) && $stable(s_trig)
             && $stable(m_base)));
endmodule

bind pic_cascade pic_cascade_chk #(
    .TRIG_ADDR(TRIG_ADDR), .M_TRIG_MASK(M_TRIG_MASK), .S_TRIG_MASK(S_TRIG_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .inta(inta), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_len(bus_len), .bus_wdata(bus_wdata), .cpu_int(cpu_int),
    .vec_valid(vec_valid), .vec_out(vec_out), .s_deliv(s_deliv), .m_base(m_base),
    .m_irr(m_irr), .m_imr(m_imr), .s_imr(s_imr), .m_trig(m_trig), .s_trig(s_trig)
);

// File: tb/pic_cascade_tb.sv
module pic_cascade_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic        inta = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_len = 3'd1;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        cpu_int;
    logic [7:0]  vec_out;
    logic        vec_valid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pic_cascade u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .inta(inta),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_len(bus_len),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_int(cpu_int),
        .vec_out(vec_out), .vec_valid(vec_valid)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [2:0] len = 3'd1);
        bus_addr = a; bus_wdata = d; bus_len = len; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_len = 3'd1;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d, input logic [2:0] len = 3'd1);
        bus_addr = a; bus_len = len; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_len = 3'd1;
        d = bus_rdata;
    endtask

    task automatic ack(input string req, input logic [7:0] exp);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        check({req, " vec_valid"}, {7'd0, vec_valid}, 8'h01);
        check({req, " vector"}, vec_out, exp);
        @(negedge clk);
        check("R6 valid single cycle", {7'd0, vec_valid}, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 cpu_int", {7'd0, cpu_int}, 8'h00);
        check("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
        check("R1 vec_out", vec_out, 8'h00);
        rd(16'h0021, v); check("R1 master mask", v, 8'h00);
        rd(16'h04D1, v); check("R1 slave trig", v, 8'h00);
    endtask

    task automatic t_init();
        logic [7:0] v;
        wr(16'h0021, 8'h55);
        wr(16'h0020, 8'h11); wr(16'h0021, 8'h08);
        rd(16'h0021, v); check("R12 init clears mask", v, 8'h00);
        wr(16'h00A0, 8'h11); wr(16'h00A1, 8'h70);
    endtask

    task automatic t_trig_mask();
        logic [7:0] v;
        wr(16'h04D0, 8'hFF); rd(16'h04D0, v); check("R10 master trig mask", v, 8'hF8);
        wr(16'h04D1, 8'hFF); rd(16'h04D1, v); check("R10 slave trig mask", v, 8'hDE);
        wr(16'h04D0, 8'h00); wr(16'h04D1, 8'h00);
    endtask

    task automatic t_spurious_master();
        ack("R8 master spurious", 8'h0F);
        check("R8 no interrupt after", {7'd0, cpu_int}, 8'h00);
    endtask

    task automatic t_edge();
        irq_lines[0] = 1'b1; step(1);
        check("R2 edge raises int", {7'd0, cpu_int}, 8'h01);
        ack("R6 master vector", 8'h08);
        wr(16'h0020, 8'h20); step(1);
        check("R2 held line no retrigger", {7'd0, cpu_int}, 8'h00);
        irq_lines[0] = 1'b0; step(1);
    endtask

    task automatic t_priority();
        logic [7:0] v;
        irq_lines[1] = 1'b1; irq_lines[5] = 1'b1; step(1);
        ack("R5 lowest index wins", 8'h09);
        check("R5 in-service blocks lower", {7'd0, cpu_int}, 8'h00);
        wr(16'h0020, 8'h20);
        check("R5 follow-on after EOI", {7'd0, cpu_int}, 8'h01);
        ack("R5 second vector", 8'h0D);
        wr(16'h0020, 8'h65);
        wr(16'h0020, 8'h0B); rd(16'h0020, v);
        check("R5 specific EOI clears isr", v, 8'h00);
        wr(16'h0020, 8'h0A);
        irq_lines[1] = 1'b0; irq_lines[5] = 1'b0; step(1);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        wr(16'h0021, 8'h08);
        irq_lines[3] = 1'b1; step(1);
        check("R4 masked no int", {7'd0, cpu_int}, 8'h00);
        rd(16'h0020, v); check("R4 request visible", v & 8'h08, 8'h08);
        wr(16'h0021, 8'h00);
        check("R4 unmask raises int", {7'd0, cpu_int}, 8'h01);
        ack("R4 vector", 8'h0B);
        wr(16'h0020, 8'h20);
        irq_lines[3] = 1'b0; step(1);
    endtask

    task automatic t_level();
        wr(16'h04D0, 8'h08);
        irq_lines[3] = 1'b1; step(1);
        ack("R3 level vector", 8'h0B);
        check("R3 blocked while in service", {7'd0, cpu_int}, 8'h00);
        wr(16'h0020, 8'h20);
        check("R3 level reasserts after EOI", {7'd0, cpu_int}, 8'h01);
        irq_lines[3] = 1'b0; step(1);
        check("R3 level drop clears", {7'd0, cpu_int}, 8'h00);
        wr(16'h04D0, 8'h00);
    endtask

    task automatic t_cascade();
        logic [7:0] v;
        irq_lines[10] = 1'b1; step(2);
        check("R7 slave raises int", {7'd0, cpu_int}, 8'h01);
        ack("R7 slave vector", 8'h72);
        wr(16'h0020, 8'h0B); rd(16'h0020, v); check("R7 master isr", v, 8'h04);
        wr(16'h00A0, 8'h0B); rd(16'h00A0, v); check("R7 slave isr", v, 8'h04);
        wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20);
        wr(16'h0020, 8'h0A); wr(16'h00A0, 8'h0A);
        irq_lines[10] = 1'b0; step(2);
        check("R7 quiet after EOI", {7'd0, cpu_int}, 8'h00);
    endtask

    task automatic t_slave_spurious();
        wr(16'h04D1, 8'h02);
        irq_lines[9] = 1'b1; step(2);
        irq_lines[9] = 1'b0; step(1);
        check("R9 latched cascade request", {7'd0, cpu_int}, 8'h01);
        ack("R9 slave spurious", 8'h77);
        wr(16'h0020, 8'h20); wr(16'h04D1, 8'h00);
    endtask

    task automatic t_wide();
        logic [7:0] v;
        wr(16'h0021, 8'hFF, 3'd2);
        rd(16'h0021, v); check("R11 wide write ignored", v, 8'h00);
        wr(16'h0021, 8'h21);
        rd(16'h0021, v, 3'd4); check("R11 wide read zero", v, 8'h00);
        rd(16'h0021, v); check("R11 byte read", v, 8'h21);
        wr(16'h0021, 8'h00);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_init();
        t_trig_mask();
        t_spurious_master();
        t_edge();
        t_priority();
        t_mask();
        t_level();
        t_cascade();
        t_slave_spurious();
        t_wide();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule